// File: doc/BRIEF.md
# Credit-Gated Fetch Request Queue

This block sits between a decoupled branch predictor and the instruction cache. The predictor streams fetch-block requests into it. Each request carries a start address, a byte count and a 2-bit termination kind. The block holds them in order in a FIFO and sends the oldest to the cache read port. When the cache answers, the block sends the returned line data downstream together with the stored prediction metadata of that request.

The predictor side has no ready signal; credits control the flow instead. The predictor starts with `DEPTH` credits and spends one for each request it sends. It sends only while it holds a credit, so the block never refuses a request. The block hands credits back on `cred_ret_valid`/`cred_ret_count`. One credit comes back for each entry that completes. A redirect flush returns all held entries in one bulk update.

The cache request port is valid/ready. Once `ic_req_valid` is raised, it stays high with a stable address until `ic_req_ready` accepts it, unless a flush withdraws it. The cache response and the downstream output are valid-only. A cache read is issued only when one downstream credit is available, so the consumer always has room for what comes back. The consumer returns each credit with a `dn_credit_ret` pulse. Only one cache read is outstanding at a time.

Top module: `fetch_req_queue`

## Requirements
- R1: After reset, `out_valid`, `cred_ret_valid` and `ic_req_valid` are low, and the block holds exactly `DN_CREDITS` downstream credits: with no `dn_credit_ret` pulses, exactly `DN_CREDITS` cache reads are issued.
- R2: Every request presented with `req_valid` and no flush is queued. Requests reach `ic_req_addr`/`ic_req_bytes` in arrival order, unchanged. A request has 1 to `LINE_BYTES` bytes and never crosses a line boundary: address offset plus byte count is at most `LINE_BYTES`.
- R3: `ic_req_valid` is high exactly when the queue is non-empty, no read is outstanding, at least one downstream credit is held and `redirect_flush` is low.
- R4: After a cache request is accepted, `ic_req_valid` stays low until the cycle after the matching `ic_rsp_valid`.
- R5: Each accepted cache request consumes one downstream credit. Each `dn_credit_ret` pulse adds one. With no credit held, no request is issued. The count never exceeds `DN_CREDITS`.
- R6: A live response in cycle t gives `out_valid` in cycle t+1, with `out_data` equal to the response data. `out_addr`, `out_bytes` and `out_term` are those of the request that was read.
- R7: The cycle after each live response, `cred_ret_valid` is high with `cred_ret_count` = 1. Once the block is idle, the predictor has recovered all `DEPTH` credits.
- R8: A flush in cycle t empties the queue. In t+1, `cred_ret_count` equals the entries held in t plus one if `req_valid` was high in t; that request is dropped. No output is produced in t+1.
- R9: If a read is outstanding when a flush occurs, its response is discarded without `out_valid`, and its downstream credit is refunded. No new read is issued before that response arrives.
- R10: The termination kind is 2 bits (00 none, 01 taken branch, 10 return, 11 reserved). All four codes pass to `out_term` unchanged.
- R11: While `ic_req_valid` is high and `ic_req_ready` low, the next cycle keeps `ic_req_valid` high with the same `ic_req_addr`, unless `redirect_flush` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Predictor request strobe (sender holds a credit) |
| req_addr | input | ADDR_W | Fetch start address |
| req_bytes | input | BYTES_W | Bytes to fetch, 1..LINE_BYTES |
| req_term | input | 2 | Termination kind |
| cred_ret_valid | output | 1 | Credits returned this cycle |
| cred_ret_count | output | CNT_W | Number of credits returned |
| redirect_flush | input | 1 | Misfetch/redirect: discard all queued requests |
| ic_req_valid | output | 1 | Cache read request valid |
| ic_req_ready | input | 1 | Cache accepts the read |
| ic_req_addr | output | ADDR_W | Cache read address |
| ic_req_bytes | output | BYTES_W | Cache read byte count |
| ic_rsp_valid | input | 1 | Cache hit data returned |
| ic_rsp_data | input | DATA_W | Returned line bytes |
| dn_credit_ret | input | 1 | Downstream consumer returns one credit |
| out_valid | output | 1 | Fetched block valid |
| out_addr | output | ADDR_W | Start address of the fetched block |
| out_bytes | output | BYTES_W | Byte count of the fetched block |
| out_term | output | 2 | Termination kind of the fetched block |
| out_data | output | DATA_W | Fetched bytes |

## Verification
The bench fills the queue while the cache refuses reads and then flushes it. A design that miscounted the bulk return would strand or invent predictor credits. A flush that arrives together with a new request must also return that request's credit. The bench flushes while a read is in flight. A design that forwarded the stale response would emit `out_valid` for a dead path, and one that forgot the refund would stall once downstream credits ran out. It also withholds downstream credits after reset. A wrong credit count there shows up as too many or too few issued reads. Random traffic with all four termination codes and uneven cache latency shows any reordering or metadata mix-up as a mismatch on the output fields.

// File: rtl/fetchq_pkg.sv
package fetchq_pkg;
  // Termination kind of a fetch block
  typedef enum logic [1:0] {
    TERM_NONE   = 2'b00,
    TERM_TAKEN  = 2'b01,
    TERM_RETURN = 2'b10,
    TERM_RSVD   = 2'b11
  } term_e;
endpackage

// File: rtl/fq_fifo.sv
module fq_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head_data,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];
  assign empty     = (count == '0);
endmodule

// File: rtl/fq_dn_credits.sv
module fq_dn_credits #(
  parameter  int MAX = 4,
  localparam int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         give_a,
  input  logic         give_b,
  output logic [W-1:0] avail,
  output logic         has_credit
);
  always_ff @(posedge clk) begin
    if (!rst_n) avail <= W'(MAX);
    else        avail <= avail - W'(take) + W'(give_a) + W'(give_b);
  end

  assign has_credit = (avail != '0);
endmodule

// File: rtl/fq_inflight.sv
module fq_inflight (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic rsp,
  input  logic flush,
  output logic busy,
  output logic drop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      drop <= 1'b0;
    end else begin
      if (issue)    busy <= 1'b1;
      else if (rsp) busy <= 1'b0;
      if (rsp)                drop <= 1'b0;
      else if (flush && busy) drop <= 1'b1;
    end
  end
endmodule

// File: rtl/fetch_req_queue.sv
module fetch_req_queue
  import fetchq_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 16,
  parameter  int DEPTH      = 8,
  parameter  int DN_CREDITS = 4,
  localparam int BYTES_W    = $clog2(LINE_BYTES) + 1,
  localparam int DATA_W     = LINE_BYTES * 8,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int DNC_W      = $clog2(DN_CREDITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [1:0]         req_term,
  output logic               cred_ret_valid,
  output logic [CNT_W-1:0]   cred_ret_count,
  input  logic               redirect_flush,
  output logic               ic_req_valid,
  input  logic               ic_req_ready,
  output logic [ADDR_W-1:0]  ic_req_addr,
  output logic [BYTES_W-1:0] ic_req_bytes,
  input  logic               ic_rsp_valid,
  input  logic [DATA_W-1:0]  ic_rsp_data,
  input  logic               dn_credit_ret,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [BYTES_W-1:0] out_bytes,
  output logic [1:0]         out_term,
  output logic [DATA_W-1:0]  out_data
);
  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [BYTES_W-1:0] bytes;
    term_e              term;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  entry_t             push_e, head_e;
  logic [ENTRY_W-1:0] head_bits;
  logic [CNT_W-1:0]   occ;
  logic               q_empty;
  logic               push, issue, rsp_seen, rsp_live, refund;
  logic               busy, drop;
  logic [DNC_W-1:0]   dn_avail;
  logic               dn_ok;

  assign push_e = '{addr: req_addr, bytes: req_bytes, term: term_e'(req_term)};
  assign head_e = entry_t'(head_bits);

  // Requests arriving with a flush belong to the discarded path
  assign push     = req_valid & ~redirect_flush;
  assign rsp_seen = ic_rsp_valid & busy;
  assign rsp_live = rsp_seen & ~drop & ~redirect_flush;
  assign refund   = rsp_seen & (drop | redirect_flush);

  assign ic_req_valid = ~q_empty & ~busy & dn_ok & ~redirect_flush;
  assign ic_req_addr  = head_e.addr;
  assign ic_req_bytes = head_e.bytes;
  assign issue        = ic_req_valid & ic_req_ready;

  fq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_e),
    .pop       (rsp_live),
    .flush     (redirect_flush),
    .head_data (head_bits),
    .count     (occ),
    .empty     (q_empty)
  );

  fq_dn_credits #(.MAX(DN_CREDITS)) u_dn (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (issue),
    .give_a     (dn_credit_ret),
    .give_b     (refund),
    .avail      (dn_avail),
    .has_credit (dn_ok)
  );

  fq_inflight u_inflight (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .rsp   (rsp_seen),
    .flush (redirect_flush),
    .busy  (busy),
    .drop  (drop)
  );

  // Output stage: data paired with the metadata of the entry being retired
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_bytes <= '0;
      out_term  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= rsp_live;
      if (rsp_live) begin
        out_addr  <= head_e.addr;
        out_bytes <= head_e.bytes;
        out_term  <= head_e.term;
        out_data  <= ic_rsp_data;
      end
    end
  end

  // Credit return: one per retired entry, bulk on flush
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cred_ret_valid <= 1'b0;
      cred_ret_count <= '0;
    end else if (redirect_flush) begin
      cred_ret_valid <= (occ != '0) | req_valid;
      cred_ret_count <= occ + CNT_W'(req_valid);
    end else begin
      cred_ret_valid <= rsp_live;
      cred_ret_count <= CNT_W'(rsp_live);
    end
  end
endmodule

// File: rtl/fetch_req_queue_chk.sv
module fetch_req_queue_chk #(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 16,
  parameter  int DEPTH      = 8,
  parameter  int DN_CREDITS = 4,
  localparam int BYTES_W    = $clog2(LINE_BYTES) + 1,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int DNC_W      = $clog2(DN_CREDITS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BYTES_W-1:0] req_bytes,
  input logic               redirect_flush,
  input logic               ic_req_valid,
  input logic               ic_req_ready,
  input logic [ADDR_W-1:0]  ic_req_addr,
  input logic               ic_rsp_valid,
  input logic               out_valid,
  input logic               cred_ret_valid,
  input logic [CNT_W-1:0]   cred_ret_count,
  input logic [DNC_W-1:0]   dn_avail,
  input logic               busy
);
  // R2
  req_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0) &&
                  (32'(req_addr[OFF_W-1:0]) + 32'(req_bytes) <= LINE_BYTES));

  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_valid && ic_req_ready) |=> !ic_req_valid);

  // R5
  dn_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dn_avail) <= DN_CREDITS);

  // R7
  out_cred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cred_ret_valid && (cred_ret_count == CNT_W'(1)));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_flush |=> !out_valid);

  // R9
  rsp_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_rsp_valid |-> busy);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_valid && !ic_req_ready) |=>
      (redirect_flush || (ic_req_valid && $stable(ic_req_addr))));
endmodule

bind fetch_req_queue fetch_req_queue_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH), .DN_CREDITS(DN_CREDITS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_bytes      (req_bytes),
  .redirect_flush (redirect_flush),
  .ic_req_valid   (ic_req_valid),
  .ic_req_ready   (ic_req_ready),
  .ic_req_addr    (ic_req_addr),
  .ic_rsp_valid   (ic_rsp_valid),
  .out_valid      (out_valid),
  .cred_ret_valid (cred_ret_valid),
  .cred_ret_count (cred_ret_count),
  .dn_avail       (dn_avail),
  .busy           (busy)
);

// File: tb/fetch_req_queue_bench.sv
module fetch_req_queue_bench;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int DEPTH = 8;
  localparam int DNC = 4;
  localparam int BW = $clog2(LB) + 1;
  localparam int DW = LB * 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_bytes = '0;
  logic [1:0]    req_term = '0;
  logic          cred_ret_valid;
  logic [CW-1:0] cred_ret_count;
  logic          redirect_flush = 1'b0;
  logic          ic_req_valid;
  logic          ic_req_ready = 1'b0;
  logic [AW-1:0] ic_req_addr;
  logic [BW-1:0] ic_req_bytes;
  logic          ic_rsp_valid = 1'b0;
  logic [DW-1:0] ic_rsp_data = '0;
  logic          dn_credit_ret = 1'b0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [BW-1:0] out_bytes;
  logic [1:0]    out_term;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  fetch_req_queue #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DEPTH), .DN_CREDITS(DNC))
  u_fetch_req_queue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes), .req_term(req_term),
    .cred_ret_valid(cred_ret_valid), .cred_ret_count(cred_ret_count),
    .redirect_flush(redirect_flush),
    .ic_req_valid(ic_req_valid), .ic_req_ready(ic_req_ready),
    .ic_req_addr(ic_req_addr), .ic_req_bytes(ic_req_bytes),
    .ic_rsp_valid(ic_rsp_valid), .ic_rsp_data(ic_rsp_data),
    .dn_credit_ret(dn_credit_ret),
    .out_valid(out_valid), .out_addr(out_addr), .out_bytes(out_bytes),
    .out_term(out_term), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [AW-1:0] q_addr [$];
  logic [BW-1:0] q_bytes [$];
  logic [1:0]    q_term [$];
  int pred_cred = DEPTH;
  int dn_cnt = DNC;
  int owed = 0;
  int n_issue = 0;
  bit m_busy = 0, m_drop = 0, c_busy = 0;
  int c_timer = 0;
  logic [AW-1:0] c_addr = '0;
  bit prev_wait = 0;
  logic [AW-1:0] prev_addr = '0;

  bit            exp_ov = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [BW-1:0] exp_bytes = '0;
  logic [1:0]    exp_term = '0;
  logic [DW-1:0] exp_data = '0;
  int            exp_cred = 0;
  string         tag_out = "R6";
  string         tag_cred = "R7";

  int p_req = 0, p_flush = 0, p_ready = 0, p_dnret = 0;
  bit fixed_lat = 0;

  function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
    return {a * 32'd3, ~a, a ^ 32'hA5A5_5A5A, a + 32'd1};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: called at a falling edge, returns at the next falling edge
  task automatic step(input bit force_flush);
    bit fl, hs, rsp, live, refund, exp_rv, dr;
    string t;
    int off;
    // registered outputs from the previous edge
    chk(out_valid == exp_ov, tag_out, DW'(out_valid), DW'(exp_ov));
    if (exp_ov && out_valid) begin
      chk(out_addr == exp_addr, "R6 addr", DW'(out_addr), DW'(exp_addr));
      chk(out_bytes == exp_bytes, "R6 bytes", DW'(out_bytes), DW'(exp_bytes));
      chk(out_term == exp_term, "R10 term", DW'(out_term), DW'(exp_term));
      chk(out_data == exp_data, "R6 data", out_data, exp_data);
    end
    if (out_valid) owed++;
    chk(cred_ret_valid == (exp_cred != 0), tag_cred, DW'(cred_ret_valid), DW'(exp_cred != 0));
    if (exp_cred != 0)
      chk(int'(cred_ret_count) == exp_cred, tag_cred, DW'(cred_ret_count), DW'(exp_cred));
    if (cred_ret_valid) pred_cred += int'(cred_ret_count);

    // drive inputs
    req_valid = 1'b0;
    if (pred_cred > 0 && int'($urandom % 100) < p_req) begin
      off = int'($urandom % LB);
      req_valid = 1'b1;
      req_addr  = {$urandom, 4'b0000} | AW'(off);
      req_bytes = BW'(1 + ($urandom % (LB - off)));
      req_term  = 2'($urandom);
      pred_cred--;
    end
    fl = force_flush || (int'($urandom % 1000) < p_flush);
    redirect_flush = fl;
    ic_req_ready = (int'($urandom % 100) < p_ready);
    rsp = c_busy && (c_timer == 0);
    ic_rsp_valid = rsp;
    ic_rsp_data  = rsp ? line_data(c_addr) : '0;
    if (c_busy && c_timer > 0) c_timer--;
    dr = (owed > 0) && (int'($urandom % 100) < p_dnret);
    dn_credit_ret = dr;
    if (dr) owed--;
    #1;

    // combinational cache request
    exp_rv = (q_addr.size() > 0) && !m_busy && (dn_cnt > 0) && !fl;
    if (m_busy) t = "R4"; else if (dn_cnt == 0) t = "R5"; else if (fl) t = "R8"; else t = "R3";
    chk(ic_req_valid == exp_rv, t, DW'(ic_req_valid), DW'(exp_rv));
    if (exp_rv && ic_req_valid) begin
      chk(ic_req_addr == q_addr[0], "R2 addr", DW'(ic_req_addr), DW'(q_addr[0]));
      chk(ic_req_bytes == q_bytes[0], "R2 bytes", DW'(ic_req_bytes), DW'(q_bytes[0]));
    end
    if (prev_wait && !fl)
      chk(ic_req_valid && (ic_req_addr == prev_addr), "R11", DW'(ic_req_addr), DW'(prev_addr));
    hs = ic_req_valid && ic_req_ready;
    prev_wait = ic_req_valid && !ic_req_ready;
    prev_addr = ic_req_addr;
    if (hs) n_issue++;

    // model update for this edge
    live   = rsp && !m_drop && !fl;
    refund = rsp && (m_drop || fl);
    exp_ov = live;
    if (refund) tag_out = "R9"; else if (fl) tag_out = "R8"; else tag_out = "R6";
    if (live) begin
      exp_addr  = q_addr[0];
      exp_bytes = q_bytes[0];
      exp_term  = q_term[0];
      exp_data  = line_data(q_addr[0]);
    end
    if (hs) begin
      m_busy = 1; c_busy = 1; c_addr = q_addr[0];
      c_timer = fixed_lat ? 2 : int'($urandom % 3);
    end
    if (rsp) begin
      m_busy = 0; m_drop = 0; c_busy = 0;
    end else if (fl && m_busy) m_drop = 1;
    tag_cred = fl ? "R8" : "R7";
    if (fl) begin
      exp_cred = q_addr.size() + int'(req_valid);
      q_addr.delete(); q_bytes.delete(); q_term.delete();
    end else begin
      exp_cred = live ? 1 : 0;
      if (live) begin
        void'(q_addr.pop_front()); void'(q_bytes.pop_front()); void'(q_term.pop_front());
      end
      if (req_valid) begin
        q_addr.push_back(req_addr); q_bytes.push_back(req_bytes); q_term.push_back(req_term);
      end
    end
    dn_cnt = dn_cnt - int'(hs) + int'(dr) + int'(refund);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    p_req = 0; p_flush = 0; p_ready = 100; p_dnret = 100;
    for (int i = 0; i < 400; i++) begin
      if (q_addr.size() == 0 && !m_busy && !exp_ov && exp_cred == 0 && owed == 0) break;
      step(0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", DW'(out_valid), '0);
    chk(cred_ret_valid == 1'b0, "R1 cred_ret_valid", DW'(cred_ret_valid), '0);
    chk(ic_req_valid == 1'b0, "R1 ic_req_valid", DW'(ic_req_valid), '0);

    // R1/R5: downstream credits withheld, exactly DNC reads possible
    p_req = 100; p_ready = 100; p_dnret = 0; p_flush = 0;
    for (int i = 0; i < 30; i++) step(0);
    chk(n_issue == DNC, "R1 issued reads", DW'(n_issue), DW'(DNC));

    // R8: fill the queue with the cache refusing, then bulk flush
    p_dnret = 100; p_ready = 0;
    for (int i = 0; i < 15; i++) step(0);
    step(1);
    step(0);

    // R9: flush while a read is in flight
    drain();
    p_req = 100; p_ready = 100; fixed_lat = 1;
    step(0);
    p_req = 0;
    for (int i = 0; i < 10 && !m_busy; i++) step(0);
    step(1);
    for (int i = 0; i < 10 && m_busy; i++) step(0);
    chk(m_busy == 0, "R9 response returned", DW'(m_busy), '0);
    fixed_lat = 0;
    step(0); step(0);

    // Random mixed traffic, all termination codes (R10)
    p_req = 60; p_ready = 70; p_dnret = 40; p_flush = 15;
    for (int i = 0; i < 4000; i++) step(0);

    // R7: every credit recovered once idle
    drain();
    step(0);
    chk(pred_cred == DEPTH, "R7 predictor credits", DW'(pred_cred), DW'(DEPTH));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule